// File: doc/BRIEF.md
# Switch Port-Mask Forwarding Resolver

This block decides which egress ports of a small Ethernet switch receive a frame. One shared table of port-group masks, one bit per egress port, is read three times per frame. The first read yields the destination set, the second the link-aggregation member choice for the flow, and the third the set of ports the ingress port may reach. The egress mask is the bitwise AND of the three reads. The CPU port is the bit just above the physical ports.

Each frame arrives as a descriptor with these fields: a MAC-table hit flag and the index carried by the matched entry, the destination MAC, the ingress port, and a 4-bit link aggregation code. On a MAC-table miss, the destination MAC is classified as unicast, multicast or broadcast. One of three flood-index registers then supplies the destination entry. A plain address/data/write-enable port loads table entries and flood registers.

Descriptors enter on a valid/ready stream and masks leave on a valid/ready stream. A descriptor transfers on a clock edge where `in_valid` and `in_ready` are both high, and a mask transfers where `out_valid` and `out_ready` are both high. While a mask is held unaccepted, the whole three-stage pipeline freezes and `in_ready` is low. A held mask never changes and never drops.

Top module: `pmr_top`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high. Table entry i for i below NUM_PORTS holds only bit i set. Every other entry holds all ones, which includes the CPU bit at position NUM_PORTS. The flood indices reset to 60 for unicast and 61 for both multicast and broadcast.
- R2: On a MAC-table hit, the destination mask is table entry `in_mac_idx`.
- R3: On a miss, the destination entry comes from a flood register chosen by class. A MAC of all ones is broadcast. Otherwise the MAC is multicast when bit 40 is set; bit 40 is the least significant bit of the first octet, which is `in_dmac[47:40]`. All other MACs are unicast.
- R4: The aggregation mask is table entry 64 + `in_lag_code`.
- R5: The source mask is table entry 80 + `in_src_port`. An ingress port number of NUM_PORTS or more gives an all-zero source mask.
- R6: `out_mask` is the bitwise AND of the destination, aggregation and source masks.
- R7: With `out_ready` held high, the mask for a descriptor is valid exactly three clock cycles after the descriptor is accepted. A new descriptor may be accepted every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_mask` and `out_valid` hold, `in_ready` is low, and any offered descriptor is not taken.
- R9: A write with `cfg_we` high behaves by address. Addresses 0 to 90 load that table entry from `cfg_wdata`. Addresses 124, 125 and 126 load the unicast, multicast and broadcast flood index from `cfg_wdata[5:0]`. Every other address changes nothing. The table is read on the second clock edge after a descriptor is accepted, and a write on that same edge is not seen by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Table entry or flood register address |
| cfg_wdata | input | 12 | Write data (mask, or flood index in low 6 bits) |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_mac_hit | input | 1 | Destination found in MAC table |
| in_mac_idx | input | 6 | Destination entry from the matched MAC entry |
| in_dmac | input | 48 | Destination MAC, first octet in bits 47:40 |
| in_src_port | input | 4 | Ingress port number |
| in_lag_code | input | 4 | Link aggregation code |
| out_valid | output | 1 | Egress mask valid |
| out_ready | input | 1 | Consumer accepts mask |
| out_mask | output | 12 | Egress port mask, CPU at bit 11 |

## Verification
The assertions check four things on every cycle: a held output stays frozen under back-pressure, occupancy advances through the stages, and a hit index or a broadcast flood index is captured in the first stage. They also check that the output never carries a bit outside the destination mask it was built from, and that writes to unmapped addresses leave the flood registers alone. Only the bench scenarios can show that the reset contents of the table are right, and that the class decision picks the right flood register for the edge MACs. The same applies to the exact three-cycle latency, to a write racing a read returning old data, and to a descriptor offered during a stall being dropped rather than taken.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int DMAC_W = 48;

  typedef enum logic [1:0] {
    CLS_UC = 2'd0,
    CLS_MC = 2'd1,
    CLS_BC = 2'd2
  } dmac_class_e;

  // All ones is broadcast; group bit (LSB of first octet, bit 40) is multicast.
  function automatic dmac_class_e classify_dmac(input logic [DMAC_W-1:0] mac);
    if (&mac) return CLS_BC;
    else if (mac[40]) return CLS_MC;
    else return CLS_UC;
  endfunction
endpackage

// File: rtl/pmr_dest_select.sv
module pmr_dest_select
  import pmr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              mac_hit,
  input  logic [IDX_W-1:0]  mac_idx,
  input  logic [DMAC_W-1:0] dmac,
  input  logic [IDX_W-1:0]  flood_uc,
  input  logic [IDX_W-1:0]  flood_mc,
  input  logic [IDX_W-1:0]  flood_bc,
  output logic [IDX_W-1:0]  dest_idx
);
  dmac_class_e cls;

  always_comb begin
    cls      = classify_dmac(dmac);
    dest_idx = mac_idx;
    if (!mac_hit) begin
      case (cls)
        CLS_BC:  dest_idx = flood_bc;
        CLS_MC:  dest_idx = flood_mc;
        default: dest_idx = flood_uc;
      endcase
    end
  end
endmodule

// File: rtl/pmr_mask_table.sv
module pmr_mask_table #(
  parameter int NUM_PORTS    = 11,
  parameter int DEST_ENTRIES = 64,
  parameter int LAG_W        = 4,
  parameter int IDX_W        = 6,
  parameter int SRC_W        = 4,
  parameter int ADDR_W       = 7,
  parameter int FLOOD_UC_RST = 60,
  parameter int FLOOD_MC_RST = 61,
  parameter int FLOOD_BC_RST = 61
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [NUM_PORTS:0]   cfg_wdata,
  input  logic [IDX_W-1:0]     rd_dst_idx,
  input  logic [LAG_W-1:0]     rd_lag,
  input  logic [SRC_W-1:0]     rd_src,
  output logic [NUM_PORTS:0]   rd_dst_mask,
  output logic [NUM_PORTS:0]   rd_aggr_mask,
  output logic [NUM_PORTS:0]   rd_src_mask,
  output logic [IDX_W-1:0]     flood_uc,
  output logic [IDX_W-1:0]     flood_mc,
  output logic [IDX_W-1:0]     flood_bc
);
  localparam int MASK_W    = NUM_PORTS + 1;
  localparam int AGGR_BASE = DEST_ENTRIES;
  localparam int AGGR_N    = 1 << LAG_W;
  localparam int SRC_BASE  = AGGR_BASE + AGGR_N;
  localparam int DEPTH     = SRC_BASE + NUM_PORTS;
  localparam int FLOOD_UC_A = (1 << ADDR_W) - 4;
  localparam int FLOOD_MC_A = (1 << ADDR_W) - 3;
  localparam int FLOOD_BC_A = (1 << ADDR_W) - 2;

  logic [MASK_W-1:0] tbl [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [MASK_W-1:0] RST_VAL =
      (e < NUM_PORTS) ? (MASK_W'(1) << e) : {MASK_W{1'b1}};
    logic [MASK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (cfg_we && cfg_addr == ADDR_W'(e)) q <= cfg_wdata;
    end
    assign tbl[e] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flood_uc <= IDX_W'(FLOOD_UC_RST);
      flood_mc <= IDX_W'(FLOOD_MC_RST);
      flood_bc <= IDX_W'(FLOOD_BC_RST);
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(FLOOD_UC_A)) flood_uc <= cfg_wdata[IDX_W-1:0];
      if (cfg_addr == ADDR_W'(FLOOD_MC_A)) flood_mc <= cfg_wdata[IDX_W-1:0];
      if (cfg_addr == ADDR_W'(FLOOD_BC_A)) flood_bc <= cfg_wdata[IDX_W-1:0];
    end
  end

  logic [ADDR_W-1:0] dst_addr, aggr_addr, src_addr;
  logic              src_ok;

  always_comb begin
    dst_addr     = ADDR_W'(rd_dst_idx);
    aggr_addr    = ADDR_W'(AGGR_BASE) + ADDR_W'(rd_lag);
    src_ok       = (int'(rd_src) < NUM_PORTS);
    src_addr     = src_ok ? (ADDR_W'(SRC_BASE) + ADDR_W'(rd_src)) : ADDR_W'(SRC_BASE);
    rd_dst_mask  = tbl[dst_addr];
    rd_aggr_mask = tbl[aggr_addr];
    rd_src_mask  = src_ok ? tbl[src_addr] : '0;
  end

  // R9: writes outside the table and flood registers alter no flood index
  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_addr) >= DEPTH && int'(cfg_addr) != FLOOD_UC_A &&
     int'(cfg_addr) != FLOOD_MC_A && int'(cfg_addr) != FLOOD_BC_A)
    |=> ($stable(flood_uc) && $stable(flood_mc) && $stable(flood_bc)));
endmodule

// File: rtl/pmr_top.sv
module pmr_top
  import pmr_pkg::*;
#(
  parameter int NUM_PORTS = 11,
  parameter int LAG_W     = 4,
  parameter int IDX_W     = 6,
  parameter int SRC_W     = 4,
  parameter int ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [NUM_PORTS:0]   cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_mac_hit,
  input  logic [IDX_W-1:0]     in_mac_idx,
  input  logic [DMAC_W-1:0]    in_dmac,
  input  logic [SRC_W-1:0]     in_src_port,
  input  logic [LAG_W-1:0]     in_lag_code,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PORTS:0]   out_mask
);
  localparam int MASK_W       = NUM_PORTS + 1;
  localparam int DEST_ENTRIES = 1 << IDX_W;

  logic              advance;
  logic [IDX_W-1:0]  flood_uc, flood_mc, flood_bc, dest_idx;

  // stage 1: resolved indices
  logic              s1_v;
  logic [IDX_W-1:0]  s1_dst;
  logic [LAG_W-1:0]  s1_lag;
  logic [SRC_W-1:0]  s1_src;
  // stage 2: the three masks
  logic              s2_v;
  logic [MASK_W-1:0] s2_dmask, s2_amask, s2_smask;
  logic [MASK_W-1:0] rd_dmask, rd_amask, rd_smask;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  pmr_dest_select #(.IDX_W(IDX_W)) u_dest (
    .mac_hit  (in_mac_hit),
    .mac_idx  (in_mac_idx),
    .dmac     (in_dmac),
    .flood_uc (flood_uc),
    .flood_mc (flood_mc),
    .flood_bc (flood_bc),
    .dest_idx (dest_idx)
  );

  pmr_mask_table #(
    .NUM_PORTS(NUM_PORTS), .DEST_ENTRIES(DEST_ENTRIES), .LAG_W(LAG_W),
    .IDX_W(IDX_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) u_tbl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .rd_dst_idx   (s1_dst),
    .rd_lag       (s1_lag),
    .rd_src       (s1_src),
    .rd_dst_mask  (rd_dmask),
    .rd_aggr_mask (rd_amask),
    .rd_src_mask  (rd_smask),
    .flood_uc     (flood_uc),
    .flood_mc     (flood_mc),
    .flood_bc     (flood_bc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_dst    <= '0;
      s1_lag    <= '0;
      s1_src    <= '0;
      s2_v      <= 1'b0;
      s2_dmask  <= '0;
      s2_amask  <= '0;
      s2_smask  <= '0;
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else if (advance) begin
      s1_v      <= in_valid;
      s1_dst    <= dest_idx;
      s1_lag    <= in_lag_code;
      s1_src    <= in_src_port;
      s2_v      <= s1_v;
      s2_dmask  <= rd_dmask;
      s2_amask  <= rd_amask;
      s2_smask  <= rd_smask;
      out_valid <= s2_v;
      out_mask  <= s2_dmask & s2_amask & s2_smask;
    end
  end

  // R1: no output right after reset release
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R2: a hit carries the MAC entry index into stage 1
  assert_hit_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mac_hit) |=> (s1_v && s1_dst == $past(in_mac_idx)));

  // R3: a broadcast miss takes the broadcast flood index
  assert_bcast_flood_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_mac_hit && (&in_dmac)) |=> (s1_dst == $past(flood_bc)));

  // R6: the output never holds a port outside its destination mask
  assert_and_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && advance) |=> (out_valid && ((out_mask & ~$past(s2_dmask)) == '0)));

  // R7: occupancy moves forward one stage per advancing edge
  assert_stage_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && advance) |=> s2_v);

  // R8: a held output is frozen
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)));
endmodule

// File: tb/pmr_top_bench.sv
`timescale 1ns/1ps
module pmr_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        in_valid, in_ready, in_mac_hit;
  logic [5:0]  in_mac_idx;
  logic [47:0] in_dmac;
  logic [3:0]  in_src_port, in_lag_code;
  logic        out_valid, out_ready;
  logic [11:0] out_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pmr_top u_pmr_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_mac_hit(in_mac_hit), .in_mac_idx(in_mac_idx), .in_dmac(in_dmac),
    .in_src_port(in_src_port), .in_lag_code(in_lag_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask)
  );

  typedef struct packed {
    logic        hit;
    logic [5:0]  idx;
    logic [47:0] dmac;
    logic [3:0]  src;
    logic [3:0]  lag;
    logic [11:0] exp;
  } vec_t;

  localparam int NV = 13;
  // expectations assume the setup writes made before the loop
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd3,  48'h0,            4'd0,  4'd0,  12'h008}, // R2 hit unicast entry
    '{1'b1, 6'd3,  48'h0,            4'd0,  4'd5,  12'h000}, // R4 aggregation drops port 3
    '{1'b1, 6'd1,  48'h0,            4'd4,  4'd0,  12'h000}, // R5 port 4 barred from port 1
    '{1'b1, 6'd1,  48'h0,            4'd3,  4'd0,  12'h002}, // R5 port 3 allowed
    '{1'b0, 6'd0,  48'h00AABBCCDDEE, 4'd0,  4'd0,  12'h004}, // R3 unicast flood
    '{1'b0, 6'd0,  48'h01005E000001, 4'd0,  4'd0,  12'h0F0}, // R3 multicast flood (reset idx 61)
    '{1'b0, 6'd0,  48'hFFFFFFFFFFFF, 4'd0,  4'd0,  12'h30F}, // R3 broadcast flood
    '{1'b0, 6'd0,  48'hFFFFFFFFFFFF, 4'd4,  4'd5,  12'h305}, // R6 AND of all three
    '{1'b0, 6'd0,  48'hFEFFFFFFFFFF, 4'd0,  4'd0,  12'h004}, // R3 near-broadcast, group bit clear
    '{1'b0, 6'd0,  48'hFFFFFFFFFFFE, 4'd0,  4'd0,  12'h0F0}, // R3 near-broadcast, group bit set
    '{1'b1, 6'd11, 48'h0,            4'd2,  4'd15, 12'hFFF}, // R1 default all-ones entries
    '{1'b1, 6'd10, 48'h0,            4'd10, 4'd0,  12'h400}, // R1 last one-hot entry
    '{1'b1, 6'd3,  48'h0,            4'd12, 4'd0,  12'h000}  // R5 ingress port out of range
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic hit, input logic [5:0] idx, input logic [47:0] mac,
                       input logic [3:0] src, input logic [3:0] lag);
    in_valid = 1'b1; in_mac_hit = hit; in_mac_idx = idx;
    in_dmac = mac; in_src_port = src; in_lag_code = lag;
  endtask

  task automatic send_one(input string tag, input logic hit, input logic [5:0] idx,
                          input logic [47:0] mac, input logic [3:0] src,
                          input logic [3:0] lag, input logic [11:0] exp);
    @(negedge clk);
    drive(hit, idx, mac, src, lag);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " mask"}, 32'(out_mask), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_mac_hit = 1'b0; in_mac_idx = '0; in_dmac = '0;
    in_src_port = '0; in_lag_code = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // setup (R9 write map)
    cfg_write(7'd124, 12'h002);  // unicast flood -> entry 2
    cfg_write(7'd126, 12'h03E);  // broadcast flood -> entry 62
    cfg_write(7'd61,  12'h0F0);
    cfg_write(7'd62,  12'h30F);
    cfg_write(7'd69,  12'hFF7);  // aggregation code 5
    cfg_write(7'd84,  12'hFFD);  // ingress port 4

    // vector loop, back-to-back, output expected three cycles later (R7)
    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        chk($sformatf("R7 vec%0d valid", j - 3), 32'(out_valid), 32'd1);
        chk($sformatf("R6 vec%0d mask", j - 3), 32'(out_mask), 32'(VECS[j-3].exp));
      end else begin
        chk($sformatf("R7 empty pipe cycle %0d", j), 32'(out_valid), 32'd0);
      end
      if (j < NV) drive(VECS[j].hit, VECS[j].idx, VECS[j].dmac, VECS[j].src, VECS[j].lag);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R7 pipe drains", 32'(out_valid), 32'd0);

    // R9: write racing the table read returns the old entry
    @(negedge clk);
    drive(1'b1, 6'd3, 48'h0, 4'd0, 4'd0);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 7'd3; cfg_wdata = 12'h00C;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R9 racing read old valid", 32'(out_valid), 32'd1);
    chk("R9 racing read old mask", 32'(out_mask), 32'h008);
    send_one("R9 new entry seen", 1'b1, 6'd3, 48'h0, 4'd0, 4'd0, 12'h00C);

    // R9: unmapped addresses change nothing
    cfg_write(7'd127, 12'h000);
    cfg_write(7'd100, 12'h000);
    send_one("R9 unmapped bcast", 1'b0, 6'd0, 48'hFFFFFFFFFFFF, 4'd0, 4'd0, 12'h30F);
    send_one("R9 unmapped ucast", 1'b0, 6'd0, 48'h0000000000AA, 4'd0, 4'd0, 12'h004);

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b1, 6'd7, 48'h0, 4'd0, 4'd0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 held valid", 32'(out_valid), 32'd1);
    chk("R8 held mask", 32'(out_mask), 32'h080);
    chk("R8 in_ready low", 32'(in_ready), 32'd0);
    drive(1'b1, 6'd9, 48'h0, 4'd0, 4'd0);
    repeat (2) @(negedge clk);
    chk("R8 still held mask", 32'(out_mask), 32'h080);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R8 released", 32'(out_valid), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 stalled offer not taken", 32'(out_valid), 32'd0);
    end

    finish_run();
  end
endmodule